// File: doc/BRIEF.md
# Exception Context Stacking Sequencer

This block saves and restores processor context over an AHB-Lite master port around an exception. A one-cycle start pulse, together with the current stack pointer, a direction flag and two floating-point flags, launches a run. In the save direction, the block first computes a new frame base below the stack pointer. It then writes the saved words to the frame as a fixed series of incrementing word bursts. Each data beat is sourced from a context port that is indexed by the word's offset within the frame. When the last data phase has completed, the block pulses `done`, and `spOut` holds the adjusted stack pointer.

In the restore direction, the same bursts are issued as reads based at the supplied stack pointer. Each returned word is presented on the context port with a write strobe, and the stack pointer is advanced past the frame. The control word and return address always go first, in a two-beat burst. The six integer registers follow in a six-beat burst. If floating-point state is present, it follows as one seventeen-beat burst, or as 8, 8 and 1 beats when an early register update is pending.

Top module: `ctx_stack_seq`

## Requirements
- R1: Every non-idle address phase is an incrementing burst (`hburst` = 3'b001) of word transfers (`hsize` = 3'b010).
- R2: The first burst has two beats, at frame byte offsets 24 and 28 (context indices 6 and 7).
- R3: The second burst has six beats, at frame byte offsets 0 to 20 (context indices 0 to 5).
- R4: With `fpSave` high and `fpPending` low, a third burst of 17 beats covers byte offsets 32 to 96 (indices 8 to 24).
- R5: With `fpSave` and `fpPending` both high, the indices 8 to 24 go out as three bursts of 8, 8 and 1 beats. With `fpSave` low, `fpPending` is ignored and only the first two bursts are issued.
- R6: `htrans` encodes IDLE as 2'b00, NONSEQ as 2'b10 and SEQ as 2'b11. Each burst opens with NONSEQ, and its later beats are SEQ at the previous address plus 4. At least one IDLE cycle separates two bursts.
- R7: When saving, the frame base and `spOut` equal `spIn` minus 32, or minus 104 when `fpSave` is high. Byte offset 100 of the larger frame is a reserved word and is never transferred.
- R8: While `hready` is low, the address, `htrans` and `hwrite` hold, and no beat advances.
- R9: `done` is high for exactly one cycle. That cycle is the one after the cycle in which the final data phase completes with `hready` high. `busy` is low while `done` is high.
- R10: During each write data phase, `ctxIdx` equals (transfer address minus frame base)/4, `hwdata` equals `ctxRdData`, and `hwrite` is 1.
- R11: With `unstack` high, the same bursts are issued as reads (`hwrite` = 0) based at `spIn`, and `spOut` is `spIn` plus the frame size. When a read data phase completes, `ctxWrEn` pulses with that word's index on `ctxIdx` and `hrdata` on `ctxWrData`. When saving, `ctxWrEn` stays 0.
- R12: A start pulse while `busy` is high is ignored. A start pulse in the cycle where `done` is high is accepted.
- R13: After reset, `htrans` is IDLE and `busy`, `done` and `ctxWrEn` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch pulse, sampled when idle |
| unstack | input | 1 | 1 selects restore (reads), 0 selects save (writes) |
| fpSave | input | 1 | Floating-point context is part of the frame |
| fpPending | input | 1 | Early floating-point update pending; splits the FP burst |
| spIn | input | AW | Stack pointer at launch |
| spOut | output | AW | Adjusted stack pointer |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle completion pulse |
| haddr | output | AW | Bus address |
| htrans | output | 2 | Bus transfer type |
| hwrite | output | 1 | Bus direction |
| hsize | output | 3 | Transfer size |
| hburst | output | 3 | Burst type |
| hwdata | output | DW | Write data |
| hready | input | 1 | Bus ready |
| hrdata | input | DW | Read data |
| ctxIdx | output | 5 | Word index within the frame of the current data phase |
| ctxRdData | input | DW | Context word for `ctxIdx` (save direction) |
| ctxWrEn | output | 1 | Restored word strobe |
| ctxWrData | output | DW | Restored word |

## Verification
Two events can share a cycle here: the completion pulse of one run and the acceptance of the next start. The bench provokes this by raising `start` in the very cycle where its model expects `done`. The behavioural model then requires the new run's first NONSEQ beat in the following cycle, at the new frame base. A related collision is a stall on the final data phase, which has to postpone `done` cycle by cycle. Random `hready` stalls exercise this, and the model tracks completion only on ready cycles.

// File: rtl/ctx_stack_pkg.sv
package ctx_stack_pkg;

  localparam logic [1:0] TR_IDLE   = 2'b00;
  localparam logic [1:0] TR_NONSEQ = 2'b10;
  localparam logic [1:0] TR_SEQ    = 2'b11;

  localparam logic [2:0] BURST_INCR = 3'b001;
  localparam logic [2:0] SIZE_WORD  = 3'b010;

  localparam int IDX_W        = 5;
  localparam int SEG_W        = 3;
  localparam int BASIC_WORDS  = 8;
  localparam int FP_WORDS     = 26;
  localparam int BASIC_BYTES  = BASIC_WORDS * 4;
  localparam int FP_BYTES     = FP_WORDS * 4;

  typedef struct packed {
    logic [IDX_W-1:0] off;
    logic [IDX_W-1:0] len;
  } seg_t;

  typedef struct packed {
    logic             capture;
    logic             segLoad;
    logic             beatAccept;
    logic             addrActive;
    logic [IDX_W-1:0] segOff;
    logic [IDX_W-1:0] segLen;
  } strobe_t;

  // Burst partition: return address pair, integer set, then FP words
  function automatic seg_t segTable(input logic [SEG_W-1:0] sel, input logic split);
    seg_t s;
    case (sel)
      3'd0:    s = '{off: 5'd6,  len: 5'd2};
      3'd1:    s = '{off: 5'd0,  len: 5'd6};
      3'd2:    s = split ? '{off: 5'd8, len: 5'd8} : '{off: 5'd8, len: 5'd17};
      3'd3:    s = '{off: 5'd16, len: 5'd8};
      default: s = '{off: 5'd24, len: 5'd1};
    endcase
    return s;
  endfunction

endpackage

// File: rtl/ctx_stack_ctrl.sv
module ctx_stack_ctrl
  import ctx_stack_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  input  logic    fpSave,
  input  logic    fpPending,
  input  logic    hready,
  input  logic    lastBeat,
  output strobe_t stb,
  output logic    busy,
  output logic    done
);

  typedef enum logic [1:0] {S_IDLE, S_ADDR, S_GAP, S_DRAIN} state_e;

  state_e           state;
  logic [SEG_W-1:0] seg;
  logic [SEG_W-1:0] segNext;
  logic [SEG_W-1:0] segSel;
  logic [SEG_W-1:0] numSegs;
  logic             fpSaveQ;
  logic             splitQ;
  seg_t             segInfo;

  assign segNext = seg + 3'd1;
  assign numSegs = !fpSaveQ ? 3'd2 : (splitQ ? 3'd5 : 3'd3);
  assign segSel  = (state == S_IDLE) ? '0 : segNext;
  assign segInfo = segTable(segSel, splitQ);
  assign busy    = (state != S_IDLE);

  always_comb begin
    stb        = '0;
    stb.segOff = segInfo.off;
    stb.segLen = segInfo.len;
    case (state)
      S_IDLE: begin
        stb.capture = start;
        stb.segLoad = start;
      end
      S_ADDR: begin
        stb.addrActive = 1'b1;
        stb.beatAccept = hready;
      end
      S_GAP:   stb.segLoad = hready;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      seg     <= '0;
      fpSaveQ <= 1'b0;
      splitQ  <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= (state == S_DRAIN) && hready;
      case (state)
        S_IDLE: if (start) begin
          fpSaveQ <= fpSave;
          splitQ  <= fpSave & fpPending;
          seg     <= '0;
          state   <= S_ADDR;
        end
        S_ADDR: if (hready && lastBeat)
          state <= (segNext < numSegs) ? S_GAP : S_DRAIN;
        S_GAP: if (hready) begin
          seg   <= segNext;
          state <= S_ADDR;
        end
        default: if (hready) state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/ctx_stack_dp.sv
module ctx_stack_dp
  import ctx_stack_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          stb,
  input  logic             unstack,
  input  logic             fpSave,
  input  logic [AW-1:0]    spIn,
  input  logic             hready,
  input  logic [DW-1:0]    hrdata,
  input  logic [DW-1:0]    ctxRdData,
  output logic             lastBeat,
  output logic [AW-1:0]    spOut,
  output logic [AW-1:0]    haddr,
  output logic [1:0]       htrans,
  output logic             hwrite,
  output logic [2:0]       hsize,
  output logic [2:0]       hburst,
  output logic [DW-1:0]    hwdata,
  output logic [IDX_W-1:0] ctxIdx,
  output logic             ctxWrEn,
  output logic [DW-1:0]    ctxWrData
);

  localparam logic [AW-1:0] SMALL_LEN = AW'(BASIC_BYTES);
  localparam logic [AW-1:0] LARGE_LEN = AW'(FP_BYTES);

  logic [AW-1:0]    base;
  logic [AW-1:0]    frameLen;
  logic [IDX_W-1:0] beatIdx;
  logic [IDX_W-1:0] left;
  logic             first;
  logic             modeWr;
  logic             dpValid;
  logic [IDX_W-1:0] dpIdx;

  assign frameLen = fpSave ? LARGE_LEN : SMALL_LEN;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      base    <= '0;
      spOut   <= '0;
      modeWr  <= 1'b1;
      beatIdx <= '0;
      left    <= '0;
      first   <= 1'b0;
      dpValid <= 1'b0;
      dpIdx   <= '0;
    end else begin
      if (stb.capture) begin
        modeWr <= !unstack;
        base   <= unstack ? spIn : spIn - frameLen;
        spOut  <= unstack ? spIn + frameLen : spIn - frameLen;
      end
      if (stb.segLoad) begin
        beatIdx <= stb.segOff;
        left    <= stb.segLen;
        first   <= 1'b1;
      end else if (stb.beatAccept) begin
        beatIdx <= beatIdx + 5'd1;
        left    <= left - 5'd1;
        first   <= 1'b0;
      end
      if (hready) begin
        dpValid <= stb.beatAccept;
        dpIdx   <= beatIdx;
      end
    end
  end

  assign lastBeat  = (left == 5'd1);
  assign haddr     = base + AW'({beatIdx, 2'b00});
  assign htrans    = !stb.addrActive ? TR_IDLE : (first ? TR_NONSEQ : TR_SEQ);
  assign hwrite    = modeWr;
  assign hsize     = SIZE_WORD;
  assign hburst    = BURST_INCR;
  assign hwdata    = ctxRdData;
  assign ctxIdx    = dpIdx;
  assign ctxWrEn   = dpValid & ~modeWr & hready;
  assign ctxWrData = hrdata;

endmodule

// File: rtl/ctx_stack_seq.sv
module ctx_stack_seq
  import ctx_stack_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  logic          unstack,
  input  logic          fpSave,
  input  logic          fpPending,
  input  logic [AW-1:0] spIn,
  output logic [AW-1:0] spOut,
  output logic          busy,
  output logic          done,
  output logic [AW-1:0] haddr,
  output logic [1:0]    htrans,
  output logic          hwrite,
  output logic [2:0]    hsize,
  output logic [2:0]    hburst,
  output logic [DW-1:0] hwdata,
  input  logic          hready,
  input  logic [DW-1:0] hrdata,
  output logic [4:0]    ctxIdx,
  input  logic [DW-1:0] ctxRdData,
  output logic          ctxWrEn,
  output logic [DW-1:0] ctxWrData
);

  strobe_t stb;
  logic    lastBeat;

  ctx_stack_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .start     (start),
    .fpSave    (fpSave),
    .fpPending (fpPending),
    .hready    (hready),
    .lastBeat  (lastBeat),
    .stb       (stb),
    .busy      (busy),
    .done      (done)
  );

  ctx_stack_dp #(.AW(AW), .DW(DW)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .unstack   (unstack),
    .fpSave    (fpSave),
    .spIn      (spIn),
    .hready    (hready),
    .hrdata    (hrdata),
    .ctxRdData (ctxRdData),
    .lastBeat  (lastBeat),
    .spOut     (spOut),
    .haddr     (haddr),
    .htrans    (htrans),
    .hwrite    (hwrite),
    .hsize     (hsize),
    .hburst    (hburst),
    .hwdata    (hwdata),
    .ctxIdx    (ctxIdx),
    .ctxWrEn   (ctxWrEn),
    .ctxWrData (ctxWrData)
  );

endmodule

// File: rtl/ctx_stack_seq_chk.sv
module ctx_stack_seq_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rstN,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic          hready,
  input logic          hwrite,
  input logic          ctxWrEn,
  input logic [1:0]    htrans,
  input logic [AW-1:0] haddr,
  input logic [AW-1:0] spOut
);

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !hready) |=> ($stable(haddr) && $stable(htrans) && $stable(hwrite)));

  // R6
  seq_addr_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((htrans == 2'b11) && $past(hready) && ($past(htrans) != 2'b00))
      |-> (haddr == $past(haddr) + AW'(4)));

  // R6
  seq_in_burst_chk: assert property (@(posedge clk) disable iff (!rstN)
    (htrans == 2'b11) |-> ($past(htrans) == 2'b10 || $past(htrans) == 2'b11));

  // R6
  nonseq_after_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (htrans == 2'b10) |-> ($past(htrans) != 2'b11));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!busy && $past(busy) && $past(hready)));

  // R9
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R12
  busy_start_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start) |=> $stable(spOut));

  // R11
  restore_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctxWrEn |-> (!hwrite && hready));

endmodule

bind ctx_stack_seq ctx_stack_seq_chk #(.AW(AW)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .start   (start),
  .busy    (busy),
  .done    (done),
  .hready  (hready),
  .hwrite  (hwrite),
  .ctxWrEn (ctxWrEn),
  .htrans  (htrans),
  .haddr   (haddr),
  .spOut   (spOut)
);

// File: tb/sim_ctx_stack_seq.sv
`timescale 1ns/1ps
module sim_ctx_stack_seq;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic        unstack = 1'b0;
  logic        fpSave = 1'b0;
  logic        fpPending = 1'b0;
  logic [31:0] spIn = '0;
  logic [31:0] spOut;
  logic        busy, done;
  logic [31:0] haddr;
  logic [1:0]  htrans;
  logic        hwrite;
  logic [2:0]  hsize, hburst;
  logic [31:0] hwdata;
  logic        hready = 1'b1;
  logic [31:0] hrdata = '0;
  logic [4:0]  ctxIdx;
  logic [31:0] ctxRdData;
  logic        ctxWrEn;
  logic [31:0] ctxWrData;

  int checks = 0;
  int fails  = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #2 clk = ~clk;

  assign ctxRdData = {16'hC0DE, 11'd0, ctxIdx};

  ctx_stack_seq u0 (
    .clk(clk), .rstN(rstN), .start(start), .unstack(unstack), .fpSave(fpSave),
    .fpPending(fpPending), .spIn(spIn), .spOut(spOut), .busy(busy), .done(done),
    .haddr(haddr), .htrans(htrans), .hwrite(hwrite), .hsize(hsize), .hburst(hburst),
    .hwdata(hwdata), .hready(hready), .hrdata(hrdata), .ctxIdx(ctxIdx),
    .ctxRdData(ctxRdData), .ctxWrEn(ctxWrEn), .ctxWrData(ctxWrData)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
    end
  endtask

  logic [1:0]  qTr[$];
  logic [31:0] qAddr[$];
  string       qTag[$];

  task automatic pushBurst(input logic [31:0] base, input int off, input int len, input string tag);
    for (int b = 0; b < len; b++) begin
      qTr.push_back(b == 0 ? 2'b10 : 2'b11);
      qAddr.push_back(base + 32'((off + b) * 4));
      qTag.push_back(tag);
    end
    qTr.push_back(2'b00);   // R6 gap
    qAddr.push_back('0);
    qTag.push_back("R6");
  endtask

  task automatic runOp(input logic [31:0] sp, input bit uns, input bit fp, input bit pend,
                       input bit stall, input bit glitch);
    logic [31:0] fw, base, expSp, dpA;
    bit dpV, expDone, fin, prevLow;
    int cyc;
    string fpTag;
    fw    = fp ? 32'd104 : 32'd32;
    base  = uns ? sp : sp - fw;
    expSp = uns ? sp + fw : sp - fw;
    fpTag = uns ? "R11" : (pend ? "R5" : "R4");
    qTr.delete(); qAddr.delete(); qTag.delete();
    pushBurst(base, 6, 2, uns ? "R11" : "R2");
    pushBurst(base, 0, 6, uns ? "R11" : "R3");
    if (fp && !pend) pushBurst(base, 8, 17, fpTag);
    if (fp && pend) begin
      pushBurst(base, 8, 8, fpTag);
      pushBurst(base, 16, 8, fpTag);
      pushBurst(base, 24, 1, fpTag);
    end
    start = 1'b1; spIn = sp; unstack = uns; fpSave = fp; fpPending = pend;
    @(posedge clk); #1;
    start = 1'b0;
    dpV = 0; dpA = '0; expDone = 0; fin = 0; prevLow = 0; cyc = 0;
    while (!fin && cyc < 3000) begin
      @(negedge clk);
      cyc++;
      lfsr   = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      hready = stall ? (lfsr[1:0] != 2'b00) : 1'b1;
      hrdata = dpV ? (dpA ^ 32'h5A5A_0000) : 32'hDEAD_BEEF;
      if (glitch && cyc == 3) begin
        start = 1'b1; spIn = ~sp; unstack = !uns; fpSave = !fp;
      end else if (glitch && cyc == 4) begin
        start = 1'b0;
      end
      #1;
      if (expDone) begin
        chk(done == 1'b1, "R9", "done pulse", 32'(done), 32'd1);
        chk(busy == 1'b0, "R9", "busy at done", 32'(busy), 32'd0);
        chk(spOut == expSp, uns ? "R11" : "R7", "spOut", spOut, expSp);
        if (glitch) chk(spOut == expSp, "R12", "spOut after ignored start", spOut, expSp);
        fin = 1;
      end else begin
        logic [1:0] expTr;
        string tag;
        expTr = (qTr.size() != 0) ? qTr[0] : 2'b00;
        tag   = (qTag.size() != 0) ? qTag[0] : "R6";
        if (prevLow) tag = "R8";
        chk(done == 1'b0, "R9", "early done", 32'(done), 32'd0);
        chk(htrans == expTr, tag, "htrans", 32'(htrans), 32'(expTr));
        if (expTr != 2'b00) begin
          chk(haddr == qAddr[0], tag, "haddr", haddr, qAddr[0]);
          chk(hburst == 3'b001 && hsize == 3'b010, "R1", "burst/size",
              {26'd0, hburst, hsize}, {26'd0, 3'b001, 3'b010});
          chk(hwrite == !uns, uns ? "R11" : "R10", "hwrite", 32'(hwrite), 32'(!uns));
        end
        if (dpV) begin
          logic [4:0] idx;
          idx = 5'((dpA - base) >> 2);
          if (!uns) begin
            chk(ctxIdx == idx, "R10", "ctxIdx", 32'(ctxIdx), 32'(idx));
            chk(hwdata == {16'hC0DE, 11'd0, idx}, "R10", "hwdata", hwdata, {16'hC0DE, 11'd0, idx});
            chk(ctxWrEn == 1'b0, "R11", "ctxWrEn while saving", 32'(ctxWrEn), 32'd0);
          end else if (hready) begin
            chk(ctxWrEn == 1'b1, "R11", "ctxWrEn", 32'(ctxWrEn), 32'd1);
            chk(ctxIdx == idx, "R11", "ctxIdx", 32'(ctxIdx), 32'(idx));
            chk(ctxWrData == hrdata, "R11", "ctxWrData", ctxWrData, hrdata);
          end else begin
            chk(ctxWrEn == 1'b0, "R8", "ctxWrEn in stall", 32'(ctxWrEn), 32'd0);
          end
        end
        if (hready) begin
          bit nv;
          logic [31:0] na;
          nv = (expTr != 2'b00);
          na = (qAddr.size() != 0) ? qAddr[0] : '0;
          if (qTr.size() != 0) begin
            void'(qTr.pop_front()); void'(qAddr.pop_front()); void'(qTag.pop_front());
            if (qTr.size() == 0) expDone = 1;
          end
          dpV = nv; dpA = na;
        end
        prevLow = !hready;
      end
    end
    if (!fin) chk(1'b0, "R9", "run never completed", 32'd0, 32'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk); #1;
    // R13
    chk(htrans == 2'b00, "R13", "reset htrans", 32'(htrans), 32'd0);
    chk(busy == 1'b0, "R13", "reset busy", 32'(busy), 32'd0);
    chk(done == 1'b0, "R13", "reset done", 32'(done), 32'd0);
    chk(ctxWrEn == 1'b0, "R13", "reset ctxWrEn", 32'(ctxWrEn), 32'd0);
    runOp(32'h2000_1000, 0, 0, 0, 0, 0);          // R2 R3 R7 basic save
    @(negedge clk); #1;
    runOp(32'h2000_2000, 0, 1, 0, 1, 0);          // R4 with stalls
    @(negedge clk); #1;
    runOp(32'h2000_3000, 0, 1, 1, 1, 0);          // R5 split
    @(negedge clk); #1;
    runOp(32'h2000_4000, 0, 0, 1, 1, 0);          // R5 pending ignored
    @(negedge clk); #1;
    runOp(32'h1FFF_FF00, 1, 0, 0, 1, 0);          // R11 basic restore
    @(negedge clk); #1;
    runOp(32'h1FFF_FE00, 1, 1, 1, 1, 0);          // R11 split restore
    @(negedge clk); #1;
    runOp(32'h2000_5000, 0, 1, 0, 1, 1);          // R12 start while busy
    runOp(32'h2000_6000, 1, 1, 0, 0, 0);          // R12 start in done cycle
    runOp(32'h2000_7000, 0, 0, 0, 1, 0);          // R12 back-to-back again
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule